// File: doc/BRIEF.md
# Two-Clock Initialization Mode Handshake

This block controls entry into and exit from initialization mode in a controller split across two unrelated clocks: a host register clock and a protocol-engine clock. Host software sets a request bit in a control register. The request crosses into the engine domain through a two-flop synchronizer. There the engine is halted, any frame in flight is cut off with a one-cycle abort strobe, and the transmit line is forced to the recessive level (logic 1). The engine's registered halt state then crosses back through a second two-flop synchronizer and becomes the acknowledge flag that software polls.

While the acknowledge is set, the configuration registers (two bit-timing registers, a filter control register, and a code and a mask register for each filter) accept writes. At other times they ignore writes. When the acknowledge rises, a group of seven control and status registers returns to its defaults. The request bit cannot be cleared until the acknowledge has arrived. If the mode is entered while the engine reports a frame in progress, an error flag is raised and held until the mode is left again. Register reads return data one host clock after the read strobe, whatever the mode.

Top module: `init_handshake`

## Requirements
- R1: After reset both domains are in initialization mode. `init_ack`, `eng_halt` and `eng_txd` are 1 and `eng_abort` is 0. Control (address 0) reads 0x01, status (address 1) reads 0x01, the transmit flag register (address 2) reads 0x07, and the other group registers (addresses 3 to 8) read 0x00.
- R2: Setting request bit 0 of address 0 raises `eng_halt` on the third engine clock edge after the host edge that stores the request. `init_ack` then rises on the second host clock edge after `eng_halt` rises. The acknowledge never rises while the request is clear or while the engine is running.
- R3: On the edge where `eng_halt` rises, `eng_txd` becomes 1. It stays 1 for as long as `eng_halt` is 1, whatever `eng_tx` does.
- R4: Each entry produces exactly one `eng_abort` pulse, one engine clock long, on the same edge where `eng_halt` rises.
- R5: A write to address 0 with bit 0 clear is ignored while the request is 1 and the acknowledge is 0. Once both are 1, the same write clears the request.
- R6: When `init_ack` rises, control bits 7..1 become 0 and addresses 2 to 8 return to their defaults (0x07 at address 2, 0x00 elsewhere). The request bit is kept.
- R7: Configuration registers at addresses 9 to 15 store written data only while `init_ack` is 1. Writes at other times leave them unchanged.
- R8: Status bit 1 is set if the engine's busy input was 1 on the engine edge where the mode was entered. It is cleared when the engine leaves the mode. Status bit 0 mirrors `init_ack`, and writes to status are ignored.
- R9: After the request is cleared, `eng_halt` falls on the third engine edge. On that same edge `eng_txd` starts following `eng_tx`. `init_ack` falls two host edges after `eng_halt` falls.
- R10: A read strobe gives `rd_valid` and the register's value one host clock later. Control and group registers can be written and read back both inside and outside the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| init_ack | output | 1 | Initialization acknowledge (host domain) |
| eng_clk | input | 1 | Protocol-engine clock |
| eng_rst | input | 1 | Synchronous active-high reset, engine domain |
| eng_busy | input | 1 | Engine reports a frame in progress |
| eng_tx | input | 1 | Transmit bit from the engine |
| eng_halt | output | 1 | Engine stop, high in initialization mode |
| eng_abort | output | 1 | One-cycle abort strobe on mode entry |
| eng_txd | output | 1 | Transmit line, forced to 1 while halted |

## Verification
The engine's halt, abort and transmit override are due three engine edges after the host edge that stores the request. The acknowledge is due two host edges after the halt changes, and read data is due one host edge after the strobe. The bench uses host and engine clocks whose edges never coincide. It counts engine edges from the storing host edge until the halt changes, then host edges until the acknowledge follows, and samples each output a fraction of a nanosecond after the edge that updates it. Register reads go to a scoreboard queue as expected values and are compared when `rd_valid` appears, so every register check falls on the cycle after its strobe.

// File: rtl/ihs_pkg.sv
`timescale 1ns/100ps
package ihs_pkg;
  // register map
  localparam int unsigned A_CTL   = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_GRP0  = 2;   // first register of the init-reset group
  localparam int unsigned N_GRP   = 7;   // addresses 2..8
  localparam int unsigned A_TXFLG = 2;   // transmit flag register
  localparam int unsigned A_CFG0  = 9;   // first configuration register
  localparam logic [7:0]  TXFLG_RST = 8'h07;

  function automatic logic [7:0] grp_rst_val(input int unsigned addr);
    return (addr == A_TXFLG) ? TXFLG_RST : 8'h00;
  endfunction
endpackage

// File: rtl/ihs_sync.sv
`timescale 1ns/100ps
module ihs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/ihs_eng.sv
`timescale 1ns/100ps
module ihs_eng (
  input  logic clk,
  input  logic rst,
  input  logic req_s,     // request, already synchronized
  input  logic busy_i,
  input  logic tx_i,
  output logic halt_o,
  output logic abort_o,
  output logic tx_o,
  output logic err_o
);
  logic enter, leave;

  assign enter = req_s & ~halt_o;
  assign leave = ~req_s & halt_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_o  <= 1'b1;
      abort_o <= 1'b0;
      tx_o    <= 1'b1;
      err_o   <= 1'b0;
    end else begin
      halt_o  <= req_s;
      abort_o <= enter;
      tx_o    <= req_s ? 1'b1 : tx_i;
      if (enter && busy_i) err_o <= 1'b1;
      else if (leave)      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ihs_host.sv
`timescale 1ns/100ps
module ihs_host #(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned N_FILT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          ack_i,
  input  logic          err_i,
  output logic          req_o
);
  import ihs_pkg::*;

  localparam int unsigned N_CFG  = 3 + 2 * N_FILT;
  localparam int unsigned CFG_IW = $clog2(N_CFG);
  localparam int unsigned GRP_IW = $clog2(N_GRP);

  function automatic logic [N_GRP-1:0][DW-1:0] grp_defaults();
    logic [N_GRP-1:0][DW-1:0] v;
    for (int i = 0; i < N_GRP; i++) v[i] = DW'(grp_rst_val(A_GRP0 + i));
    return v;
  endfunction
  localparam logic [N_GRP-1:0][DW-1:0] GRP_RV = grp_defaults();

  logic          req_q;
  logic [DW-1:1] ctl_gen;
  logic          ack_prev;
  logic          ack_rise;
  logic          wr_ctl;
  logic [DW-1:0] grp_q [N_GRP];
  logic [DW-1:0] cfg_q [N_CFG];

  assign ack_rise = ack_i & ~ack_prev;
  assign wr_ctl   = wr_en && (wr_addr == AW'(A_CTL));
  assign req_o    = req_q;

  // address decode helpers
  function automatic logic in_grp(input logic [AW-1:0] a);
    return ({1'b0, a} >= (AW+1)'(A_GRP0)) && ({1'b0, a} < (AW+1)'(A_GRP0 + N_GRP));
  endfunction
  function automatic logic in_cfg(input logic [AW-1:0] a);
    return ({1'b0, a} >= (AW+1)'(A_CFG0)) && ({1'b0, a} < (AW+1)'(A_CFG0 + N_CFG));
  endfunction

  logic [GRP_IW-1:0] wr_gidx, rd_gidx;
  logic [CFG_IW-1:0] wr_cidx, rd_cidx;
  assign wr_gidx = GRP_IW'(wr_addr - AW'(A_GRP0));
  assign rd_gidx = GRP_IW'(rd_addr - AW'(A_GRP0));
  assign wr_cidx = CFG_IW'(wr_addr - AW'(A_CFG0));
  assign rd_cidx = CFG_IW'(rd_addr - AW'(A_CFG0));

  // request bit with clear protection, general control bits
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b1;
      ctl_gen  <= '0;
      ack_prev <= 1'b1;
    end else begin
      ack_prev <= ack_i;
      if (wr_ctl) begin
        if (wr_data[0])  req_q <= 1'b1;
        else if (ack_i)  req_q <= 1'b0;
      end
      if (ack_rise)    ctl_gen <= '0;
      else if (wr_ctl) ctl_gen <= wr_data[DW-1:1];
    end
  end

  // group registers return to defaults when the acknowledge rises
  always_ff @(posedge clk) begin
    if (rst || ack_rise) begin
      for (int i = 0; i < N_GRP; i++) grp_q[i] <= GRP_RV[i];
    end else if (wr_en && in_grp(wr_addr)) begin
      grp_q[wr_gidx] <= wr_data;
    end
  end

  // configuration storage, written only in initialization mode
  always_ff @(posedge clk) begin
    if (wr_en && ack_i && in_cfg(wr_addr)) cfg_q[wr_cidx] <= wr_data;
  end

  // read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(A_CTL))       rd_mux = {ctl_gen, req_q};
    else if (rd_addr == AW'(A_STAT)) rd_mux = {{(DW-2){1'b0}}, err_i, ack_i};
    else if (in_grp(rd_addr))        rd_mux = grp_q[rd_gidx];
    else if (in_cfg(rd_addr))        rd_mux = cfg_q[rd_cidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/init_handshake.sv
`timescale 1ns/100ps
module init_handshake #(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned N_FILT   = 2,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic          host_clk,
  input  logic          host_rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          init_ack,
  input  logic          eng_clk,
  input  logic          eng_rst,
  input  logic          eng_busy,
  input  logic          eng_tx,
  output logic          eng_halt,
  output logic          eng_abort,
  output logic          eng_txd
);
  logic host_req;
  logic req_eng;
  logic eng_err;
  logic err_host;

  ihs_host #(.DW(DW), .AW(AW), .N_FILT(N_FILT)) u_host (
    .clk(host_clk), .rst(host_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .ack_i(init_ack), .err_i(err_host), .req_o(host_req)
  );

  // request into the engine domain
  ihs_sync #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_req_sync (
    .clk(eng_clk), .rst(eng_rst), .d(host_req), .q(req_eng)
  );

  ihs_eng u_eng (
    .clk(eng_clk), .rst(eng_rst), .req_s(req_eng),
    .busy_i(eng_busy), .tx_i(eng_tx),
    .halt_o(eng_halt), .abort_o(eng_abort), .tx_o(eng_txd), .err_o(eng_err)
  );

  // registered engine state back into the host domain
  ihs_sync #(.W(2), .STAGES(SYNC_LEN), .RST_VAL(2'b01)) u_ack_sync (
    .clk(host_clk), .rst(host_rst), .d({eng_err, eng_halt}), .q({err_host, init_ack})
  );
endmodule

// File: rtl/ihs_chk.sv
`timescale 1ns/100ps
module ihs_chk (
  input logic host_clk,
  input logic host_rst,
  input logic eng_clk,
  input logic eng_rst,
  input logic host_req,
  input logic init_ack,
  input logic eng_halt,
  input logic eng_abort,
  input logic eng_txd
);
  // R5: request cannot drop before the acknowledge is seen
  a_r5_req_held: assert property (@(posedge host_clk) disable iff (host_rst)
    (host_req && !init_ack) |=> host_req);

  // R2: acknowledge rises only with the request set and the engine halted
  a_r2_ack_needs_halt: assert property (@(posedge host_clk) disable iff (host_rst)
    $rose(init_ack) |-> (host_req && eng_halt));

  // R3: transmit line recessive while halted
  a_r3_tx_recessive: assert property (@(posedge eng_clk) disable iff (eng_rst)
    eng_halt |-> eng_txd);

  // R4: abort is a single-cycle pulse
  a_r4_abort_single: assert property (@(posedge eng_clk) disable iff (eng_rst)
    eng_abort |=> !eng_abort);

  // R4: abort coincides with the halt rising
  a_r4_abort_at_entry: assert property (@(posedge eng_clk) disable iff (eng_rst)
    eng_abort |-> (eng_halt && !$past(eng_halt)));
endmodule

bind init_handshake ihs_chk i_chk (
  .host_clk(host_clk), .host_rst(host_rst), .eng_clk(eng_clk), .eng_rst(eng_rst),
  .host_req(host_req), .init_ack(init_ack), .eng_halt(eng_halt),
  .eng_abort(eng_abort), .eng_txd(eng_txd)
);

// File: tb/test_init_handshake.sv
`timescale 1ns/100ps
module test_init_handshake;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          hclk = 1'b0, eclk = 1'b0;
  logic          hrst = 1'b1, erst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, init_ack;
  logic          eng_busy = 1'b0, eng_tx = 1'b1;
  logic          eng_halt, eng_abort, eng_txd;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] q_exp[$];
  string         q_tag[$];

  always #4 hclk = ~hclk;                 // 125 MHz host clock
  initial begin #0.3; forever #6.5 eclk = ~eclk; end  // unrelated engine clock

  init_handshake i_init_handshake (
    .host_clk(hclk), .host_rst(hrst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .init_ack(init_ack), .eng_clk(eclk), .eng_rst(erst), .eng_busy(eng_busy),
    .eng_tx(eng_tx), .eng_halt(eng_halt), .eng_abort(eng_abort), .eng_txd(eng_txd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge hclk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge hclk); wr_en = 1'b0;
  endtask

  // driver: strobe a read and push the expected value
  task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
    @(negedge hclk); rd_en = 1'b1; rd_addr = AW'(a);
    q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge hclk); rd_en = 1'b0;
  endtask

  // monitor: compare each result as it appears
  always @(negedge hclk) begin
    if (rd_valid) begin
      if (q_exp.size() == 0) check("R10 unexpected rd_valid", 1, 0);
      else check(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic enter_init(input logic busy, input logic [DW-1:0] ctl);
    int n;
    eng_busy = busy;
    @(negedge hclk); wr_en = 1'b1; wr_addr = '0; wr_data = ctl;
    @(posedge hclk); #0.1; wr_en = 1'b0;
    n = 0;
    while (!eng_halt) begin @(posedge eclk); #0.1; n++; end
    check("R2 engine edges to halt", n, 3);
    check("R3 txd recessive at halt", eng_txd, 1);
    check("R4 abort with halt", eng_abort, 1);
    fork
      begin @(posedge eclk); #0.1; check("R4 abort one cycle", eng_abort, 0); end
      begin
        int m = 0;
        while (!init_ack) begin @(posedge hclk); #0.1; m++; end
        check("R2 host edges to ack", m, 2);
      end
    join
    eng_busy = 1'b0;
  endtask

  task automatic leave_init();
    int n, m;
    eng_tx = 1'b0;
    @(negedge hclk); wr_en = 1'b1; wr_addr = '0; wr_data = '0;
    @(posedge hclk); #0.1; wr_en = 1'b0;
    n = 0;
    while (eng_halt) begin @(posedge eclk); #0.1; n++; end
    check("R9 engine edges to release", n, 3);
    check("R9 txd follows eng_tx", eng_txd, 0);
    m = 0;
    while (init_ack) begin @(posedge hclk); #0.1; m++; end
    check("R9 host edges to ack drop", m, 2);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    check("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (6) @(posedge hclk);
    @(negedge hclk); hrst = 1'b0;
    @(negedge eclk); erst = 1'b0;
    repeat (2) @(negedge hclk);
    // R1 reset state
    check("R1 ack after reset", init_ack, 1);
    check("R1 halt after reset", eng_halt, 1);
    check("R1 txd after reset", eng_txd, 1);
    check("R1 abort after reset", eng_abort, 0);
    rd(0, 8'h01, "R1 control default");
    rd(1, 8'h01, "R1 status default");
    rd(2, 8'h07, "R1 tx flag default");
    rd(5, 8'h00, "R1 group default");

    // R7 configuration writable in init mode
    wr(9, 8'h3C); wr(15, 8'hA5);
    rd(9, 8'h3C, "R7 cfg write in init");
    rd(15, 8'hA5, "R7 last cfg write in init");

    // R9 exit
    leave_init();
    rd(1, 8'h00, "R8 status after exit");
    wr(9, 8'hFF);
    rd(9, 8'h3C, "R7 cfg write ignored outside init");
    wr(1, 8'hFF);
    rd(1, 8'h00, "R8 status write ignored");

    // R10 group registers accessible outside init
    wr(3, 8'h5A); wr(2, 8'h00); wr(0, 8'h80);
    rd(3, 8'h5A, "R10 group write outside init");
    rd(2, 8'h00, "R10 tx flag write outside init");
    rd(0, 8'h80, "R10 control write outside init");

    // entry with a frame in progress
    eng_tx = 1'b0;
    enter_init(1'b1, 8'h81);
    repeat (2) @(negedge hclk);
    check("R3 txd held while halted", eng_txd, 1);
    rd(0, 8'h01, "R6 control general bits reset");
    rd(3, 8'h00, "R6 group register reset");
    rd(2, 8'h07, "R6 tx flag reset");
    rd(1, 8'h03, "R8 error on busy entry");
    wr(4, 8'h33);
    rd(4, 8'h33, "R10 group write inside init");
    leave_init();
    repeat (2) @(negedge hclk);
    rd(1, 8'h00, "R8 error cleared on exit");

    // R5 clear protection during entry
    @(negedge hclk); wr_en = 1'b1; wr_addr = '0; wr_data = 8'h01;
    @(negedge hclk); wr_data = 8'h00;
    @(negedge hclk); wr_en = 1'b0;
    check("R5 ack not yet set", init_ack, 0);
    rd(0, 8'h01, "R5 clear ignored before ack");
    while (!init_ack) @(negedge hclk);
    repeat (2) @(negedge hclk);
    rd(0, 8'h01, "R5 request kept until ack");
    rd(1, 8'h01, "R8 no error on idle entry");
    wr(0, 8'h00);
    rd(0, 8'h00, "R5 clear accepted after ack");
    repeat (12) @(negedge hclk);
    check("R9 ack dropped after clear", init_ack, 0);
    check("R9 halt released after clear", eng_halt, 0);

    repeat (4) @(negedge hclk);
    check("R10 all reads returned", q_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule